// File: doc/BRIEF.md
# Interrupt Arbitration and Entry Sequencer

This block sits next to a small 8-bit processor core and decides, once per instruction boundary, what happens next. It keeps pending latches for two hardware sources: an active-low external pin, which is edge- or level-sensitive as a parameter selects, and a one-cycle request pulse from an internal timer. It also owns the interrupt mask bit. When the core reports a boundary, the block either lets the next instruction start normally or takes control of a simple byte-wide memory port. It then pushes the core registers onto a stack, fetches a two-byte service vector and hands the new program counter back to the core. The same port is used to pull a saved frame back when the core decodes a return-from-interrupt.

A hardware request is only accepted when the mask is clear. A masked request stays latched until the mask clears. The external source always wins over the timer. A software interrupt decoded by the core is treated as an ordinary instruction: it is taken whether or not the mask is set, but only when no unmasked hardware request claims the boundary first. The core is stalled while `busy` is high. It reloads its program counter on `pcLoad`, and its full register set on `regLoad`.

Top module: `irq_entry_seq`

## Requirements
- R1: Reset clears both pending latches and the mask, sets the stack pointer to `STACK_TOP`, stops any sequence in progress and ends every bus cycle; reset has priority over every source.
- R2: Requests are examined only in a cycle where `bound` is high and the block is idle; a request that arrives between boundaries does not raise `busy` until a boundary comes.
- R3: While the mask is 1, neither hardware source starts an entry; each stays pending and is serviced at the first boundary after the mask is cleared.
- R4: If both hardware sources are pending and unmasked at a boundary, the external source is serviced and the timer remains pending.
- R5: An entry writes five bytes in five consecutive cycles to addresses SP, SP-1, ... SP-4, in this order: PC low, PC high, X, A, CCR. The pushed CCR is `ccrIn` with bit 3 replaced by the mask value held before entry. SP ends 5 lower.
- R6: After the pushes, the block reads the high byte of the vector and then the low byte (high byte at the base address). The vector bases are timer 0xFFF8, external 0xFFFA and software 0xFFFC. The following cycle `pcLoad` pulses with `pcOut` = {high, low}, and the mask is 1 from then on.
- R7: With `opSwi` high at a boundary and no unmasked hardware request, a software entry starts even when the mask is 1; an unmasked hardware request at the same boundary is serviced instead.
- R8: With `opRti` high at a boundary and no unmasked hardware request, five bytes are read from SP+1 up to SP+5 in the order CCR, A, X, PC high, PC low. SP ends 5 higher, `regLoad` pulses the next cycle with the restored values, and the mask takes bit 3 of the restored CCR.
- R9: At a boundary with nothing to service, `fetchGo` is high in that same cycle and no memory cycle follows.
- R10: The pending latch of the serviced source clears when its vector high-byte read begins. With edge sensing, an external pin held low after service raises no new request; a fresh high-to-low transition does.
- R11: A single-cycle `timerReq` pulse sets the timer pending latch, which holds until serviced or reset.
- R12: `maskSet` and `maskClr` pulses set and clear the mask while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bound | input | 1 | Core is at an instruction boundary |
| opSwi | input | 1 | Next instruction is a software interrupt |
| opRti | input | 1 | Next instruction is a return-from-interrupt |
| maskSet | input | 1 | Set the interrupt mask |
| maskClr | input | 1 | Clear the interrupt mask |
| extIrqN | input | 1 | External request pin, active low |
| timerReq | input | 1 | Timer request pulse |
| pcIn | input | ADDR_W | Core program counter |
| xIn | input | 8 | Core index register |
| aIn | input | 8 | Core accumulator |
| ccrIn | input | 8 | Core condition codes |
| memRdata | input | 8 | Read data, valid in the same cycle as the address |
| memAddr | output | ADDR_W | Memory address |
| memWdata | output | 8 | Write data |
| memWe | output | 1 | Write strobe |
| memRe | output | 1 | Read strobe |
| pcOut | output | ADDR_W | New or restored program counter |
| xOut | output | 8 | Restored index register |
| aOut | output | 8 | Restored accumulator |
| ccrOut | output | 8 | Restored condition codes |
| pcLoad | output | 1 | Core loads `pcOut` (entry done) |
| regLoad | output | 1 | Core loads all restored registers (return done) |
| busy | output | 1 | Sequence in progress, core stalled |
| fetchGo | output | 1 | Boundary passes through to a normal fetch |
| maskOut | output | 1 | Current mask bit |
| pendExtOut | output | 1 | External request pending |
| pendTimOut | output | 1 | Timer request pending |
| spOut | output | ADDR_W | Stack pointer |

## Verification
The bench builds the block with a 16-bit address, edge sensing on the external pin and `STACK_TOP` = 0x007F. With these values the stack bytes and all three vectors fall into a 256-byte memory model and do not collide. Edge sensing makes the held-low pin and re-arm behaviour observable. The scenarios walk one entry path per source, a masked boundary that must only fetch, a masked software entry whose saved CCR carries a 1 in bit 3, an external-over-timer collision with the timer served afterwards, and a reset during pushes.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  localparam int FRAME_BYTES = 5;
  localparam int SLOT_W      = $clog2(FRAME_BYTES);

  typedef enum logic [1:0] {
    SRC_TIM = 2'd0,
    SRC_EXT = 2'd1,
    SRC_SWI = 2'd2
  } srcSel_t;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_PUSH = 3'd1,
    S_VHI  = 3'd2,
    S_VLO  = 3'd3,
    S_PULL = 3'd4
  } seqState_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic              capture;
    logic              push;
    logic              pull;
    logic [SLOT_W-1:0] slot;
    logic              vecHi;
    logic              vecLo;
    srcSel_t           src;
    logic              restoreEnd;
  } seqStrobe_t;

endpackage

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter bit EXT_EDGE = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic extIrqN,
  input  logic timerReq,
  input  logic clrExt,
  input  logic clrTim,
  output logic pendExt,
  output logic pendTim
);

  logic setExt;

  generate
    if (EXT_EDGE) begin : g_edge
      logic pinPrev;
      // keeps tracking the pin through reset so a low pin at release is no edge
      always_ff @(posedge clk) pinPrev <= extIrqN;
      assign setExt = pinPrev & ~extIrqN;
    end else begin : g_level
      assign setExt = ~extIrqN;
    end
  endgenerate

  // a new request in the clear cycle wins over the clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendExt <= 1'b0;
      pendTim <= 1'b0;
    end else begin
      pendExt <= setExt | (pendExt & ~clrExt);
      pendTim <= timerReq | (pendTim & ~clrTim);
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!pendExt && !pendTim));

  p_clear_on_fetch_r10: assert property (@(posedge clk) disable iff (!rstN)
    (clrExt && !setExt) |=> !pendExt);

  p_timer_holds_r11: assert property (@(posedge clk) disable iff (!rstN)
    (pendTim && !clrTim) |=> pendTim);

endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bound,
  input  logic       opSwi,
  input  logic       opRti,
  input  logic       pendExt,
  input  logic       pendTim,
  input  logic       maskQ,
  output seqStrobe_t st,
  output logic       busy,
  output logic       fetchGo
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_BYTES - 1);
  localparam logic [SLOT_W-1:0] SLOT_ONE  = SLOT_W'(1);

  seqState_t         stateQ, stateD;
  logic [SLOT_W-1:0] slotQ, slotD;
  srcSel_t           srcQ, srcD;
  logic              takeEntry;
  logic              hwExt, hwTim;

  assign hwExt = pendExt & ~maskQ;
  assign hwTim = pendTim & ~maskQ;

  always_comb begin
    st         = '0;
    st.src     = srcQ;
    st.slot    = slotQ;
    stateD     = stateQ;
    slotD      = slotQ;
    srcD       = srcQ;
    fetchGo    = 1'b0;
    takeEntry  = 1'b0;
    unique case (stateQ)
      S_IDLE: begin
        if (bound) begin
          if (hwExt) begin
            srcD      = SRC_EXT;
            takeEntry = 1'b1;
          end else if (hwTim) begin
            srcD      = SRC_TIM;
            takeEntry = 1'b1;
          end else if (opSwi) begin
            srcD      = SRC_SWI;
            takeEntry = 1'b1;
          end else if (opRti) begin
            stateD = S_PULL;
            slotD  = '0;
          end else begin
            fetchGo = 1'b1;
          end
          if (takeEntry) begin
            st.capture = 1'b1;
            stateD     = S_PUSH;
            slotD      = '0;
          end
        end
      end
      S_PUSH: begin
        st.push = 1'b1;
        if (slotQ == LAST_SLOT) stateD = S_VHI;
        else                    slotD  = slotQ + SLOT_ONE;
      end
      S_VHI: begin
        st.vecHi = 1'b1;
        stateD   = S_VLO;
      end
      S_VLO: begin
        st.vecLo = 1'b1;
        stateD   = S_IDLE;
      end
      S_PULL: begin
        st.pull = 1'b1;
        if (slotQ == LAST_SLOT) begin
          st.restoreEnd = 1'b1;
          stateD        = S_IDLE;
        end else begin
          slotD = slotQ + SLOT_ONE;
        end
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      slotQ  <= '0;
      srcQ   <= SRC_TIM;
    end else begin
      stateQ <= stateD;
      slotQ  <= slotD;
      srcQ   <= srcD;
    end
  end

  assign busy = (stateQ != S_IDLE);

  p_no_start_off_boundary_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !bound) |=> !busy);

  p_masked_no_entry_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && bound && maskQ && !opSwi && !opRti) |=> !busy);

  p_ext_over_timer_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && bound && pendExt && pendTim && !maskQ) |=> (srcQ == SRC_EXT));

  p_swi_under_mask_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && bound && opSwi && maskQ) |=> (stateQ == S_PUSH && srcQ == SRC_SWI));

endmodule

// File: rtl/irq_seq_dpath.sv
module irq_seq_dpath
  import irq_seq_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] STACK_TOP = ADDR_W'(16'h00FF),
  parameter logic [ADDR_W-1:0] VEC_TIM   = ADDR_W'(16'hFFF8),
  parameter logic [ADDR_W-1:0] VEC_EXT   = ADDR_W'(16'hFFFA),
  parameter logic [ADDR_W-1:0] VEC_SWI   = ADDR_W'(16'hFFFC),
  parameter int                MASK_BIT  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        st,
  input  logic              maskSetIn,
  input  logic              maskClrIn,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [7:0]        xIn,
  input  logic [7:0]        aIn,
  input  logic [7:0]        ccrIn,
  input  logic [7:0]        memRdata,
  output logic              clrExt,
  output logic              clrTim,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic              memWe,
  output logic              memRe,
  output logic              maskQ,
  output logic [ADDR_W-1:0] spQ,
  output logic [ADDR_W-1:0] pcOut,
  output logic [7:0]        xOut,
  output logic [7:0]        aOut,
  output logic [7:0]        ccrOut,
  output logic              pcLoad,
  output logic              regLoad
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] savePc;
  logic [7:0]        saveX, saveA, saveCcr;
  logic [7:0]        ccrMerged;
  logic [7:0]        hiQ;
  logic [ADDR_W-1:0] vecBase;

  always_comb begin
    ccrMerged           = ccrIn;
    ccrMerged[MASK_BIT] = maskQ;
  end

  always_comb begin
    unique case (st.src)
      SRC_EXT: vecBase = VEC_EXT;
      SRC_TIM: vecBase = VEC_TIM;
      default: vecBase = VEC_SWI;
    endcase
  end

  // push order by slot: PC low, PC high, X, A, CCR
  always_comb begin
    unique case (st.slot)
      3'd0:    memWdata = savePc[7:0];
      3'd1:    memWdata = 8'(savePc >> 8);
      3'd2:    memWdata = saveX;
      3'd3:    memWdata = saveA;
      default: memWdata = saveCcr;
    endcase
    if (!st.push) memWdata = '0;
  end

  always_comb begin
    if (st.push)       memAddr = spQ;
    else if (st.pull)  memAddr = spQ + ONE;
    else if (st.vecHi) memAddr = vecBase;
    else if (st.vecLo) memAddr = vecBase + ONE;
    else               memAddr = '0;
  end

  assign memWe  = st.push;
  assign memRe  = st.pull | st.vecHi | st.vecLo;
  assign clrExt = st.vecHi & (st.src == SRC_EXT);
  assign clrTim = st.vecHi & (st.src == SRC_TIM);

  always_ff @(posedge clk) begin
    if (st.capture) begin
      savePc  <= pcIn;
      saveX   <= xIn;
      saveA   <= aIn;
      saveCcr <= ccrMerged;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spQ     <= STACK_TOP;
      maskQ   <= 1'b0;
      hiQ     <= '0;
      pcOut   <= '0;
      xOut    <= '0;
      aOut    <= '0;
      ccrOut  <= '0;
      pcLoad  <= 1'b0;
      regLoad <= 1'b0;
    end else begin
      pcLoad  <= 1'b0;
      regLoad <= 1'b0;
      if (st.push) spQ <= spQ - ONE;
      if (st.pull) spQ <= spQ + ONE;
      if (st.vecHi) hiQ <= memRdata;
      if (st.vecLo) begin
        pcOut  <= ADDR_W'({hiQ, memRdata});
        pcLoad <= 1'b1;
      end
      // pull order by slot: CCR, A, X, PC high, PC low
      if (st.pull) begin
        unique case (st.slot)
          3'd0:    ccrOut <= memRdata;
          3'd1:    aOut   <= memRdata;
          3'd2:    xOut   <= memRdata;
          3'd3:    hiQ    <= memRdata;
          default: begin
            pcOut   <= ADDR_W'({hiQ, memRdata});
            regLoad <= 1'b1;
          end
        endcase
      end
      if (st.vecHi)           maskQ <= 1'b1;
      else if (st.restoreEnd) maskQ <= ccrOut[MASK_BIT];
      else if (maskSetIn)     maskQ <= 1'b1;
      else if (maskClrIn)     maskQ <= 1'b0;
    end
  end

  p_push_dec_r5: assert property (@(posedge clk) disable iff (!rstN)
    st.push |=> (spQ == $past(spQ) - ONE));

  p_rw_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe));

  p_mask_after_entry_r6: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |-> maskQ);

  p_pull_inc_r8: assert property (@(posedge clk) disable iff (!rstN)
    st.pull |=> (spQ == $past(spQ) + ONE));

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] STACK_TOP = ADDR_W'(16'h00FF),
  parameter logic [ADDR_W-1:0] VEC_TIM   = ADDR_W'(16'hFFF8),
  parameter logic [ADDR_W-1:0] VEC_EXT   = ADDR_W'(16'hFFFA),
  parameter logic [ADDR_W-1:0] VEC_SWI   = ADDR_W'(16'hFFFC),
  parameter bit                EXT_EDGE  = 1'b1,
  parameter int                MASK_BIT  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bound,
  input  logic              opSwi,
  input  logic              opRti,
  input  logic              maskSet,
  input  logic              maskClr,
  input  logic              extIrqN,
  input  logic              timerReq,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [7:0]        xIn,
  input  logic [7:0]        aIn,
  input  logic [7:0]        ccrIn,
  input  logic [7:0]        memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic              memWe,
  output logic              memRe,
  output logic [ADDR_W-1:0] pcOut,
  output logic [7:0]        xOut,
  output logic [7:0]        aOut,
  output logic [7:0]        ccrOut,
  output logic              pcLoad,
  output logic              regLoad,
  output logic              busy,
  output logic              fetchGo,
  output logic              maskOut,
  output logic              pendExtOut,
  output logic              pendTimOut,
  output logic [ADDR_W-1:0] spOut
);

  seqStrobe_t st;
  logic       clrExt, clrTim;

  irq_pend #(.EXT_EDGE(EXT_EDGE)) u_pend (
    .clk     (clk),
    .rstN    (rstN),
    .extIrqN (extIrqN),
    .timerReq(timerReq),
    .clrExt  (clrExt),
    .clrTim  (clrTim),
    .pendExt (pendExtOut),
    .pendTim (pendTimOut)
  );

  irq_seq_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .bound  (bound),
    .opSwi  (opSwi),
    .opRti  (opRti),
    .pendExt(pendExtOut),
    .pendTim(pendTimOut),
    .maskQ  (maskOut),
    .st     (st),
    .busy   (busy),
    .fetchGo(fetchGo)
  );

  irq_seq_dpath #(
    .ADDR_W   (ADDR_W),
    .STACK_TOP(STACK_TOP),
    .VEC_TIM  (VEC_TIM),
    .VEC_EXT  (VEC_EXT),
    .VEC_SWI  (VEC_SWI),
    .MASK_BIT (MASK_BIT)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .maskSetIn(maskSet),
    .maskClrIn(maskClr),
    .pcIn     (pcIn),
    .xIn      (xIn),
    .aIn      (aIn),
    .ccrIn    (ccrIn),
    .memRdata (memRdata),
    .clrExt   (clrExt),
    .clrTim   (clrTim),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memWe    (memWe),
    .memRe    (memRe),
    .maskQ    (maskOut),
    .spQ      (spOut),
    .pcOut    (pcOut),
    .xOut     (xOut),
    .aOut     (aOut),
    .ccrOut   (ccrOut),
    .pcLoad   (pcLoad),
    .regLoad  (regLoad)
  );

endmodule

// File: tb/irq_entry_seq_bench.sv
`timescale 1ns/1ps
module irq_entry_seq_bench;

  localparam int          ADDR_W = 16;
  localparam logic [15:0] TOP    = 16'h007F;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, bound, opSwi, opRti, maskSet, maskClr, extIrqN, timerReq;
  logic [15:0] pcIn, memAddr, pcOut, spOut;
  logic [7:0]  xIn, aIn, ccrIn, memRdata, memWdata, xOut, aOut, ccrOut;
  logic memWe, memRe, pcLoad, regLoad, busy, fetchGo, maskOut, pendExtOut, pendTimOut;

  irq_entry_seq #(.ADDR_W(ADDR_W), .STACK_TOP(TOP), .EXT_EDGE(1'b1)) u_irq_entry_seq (
    .clk(clk), .rstN(rstN), .bound(bound), .opSwi(opSwi), .opRti(opRti),
    .maskSet(maskSet), .maskClr(maskClr), .extIrqN(extIrqN), .timerReq(timerReq),
    .pcIn(pcIn), .xIn(xIn), .aIn(aIn), .ccrIn(ccrIn), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .memRe(memRe),
    .pcOut(pcOut), .xOut(xOut), .aOut(aOut), .ccrOut(ccrOut),
    .pcLoad(pcLoad), .regLoad(regLoad), .busy(busy), .fetchGo(fetchGo),
    .maskOut(maskOut), .pendExtOut(pendExtOut), .pendTimOut(pendTimOut), .spOut(spOut)
  );

  // 256-byte memory model, combinational read
  logic [7:0] bmem [0:255];
  assign memRdata = bmem[memAddr[7:0]];
  always @(posedge clk) if (memWe) bmem[memAddr[7:0]] <= memWdata;

  int vecCount = 0;
  int missCount = 0;
  bit sbOff = 1'b0;

  int          kindQ[$];
  logic [15:0] addrQ[$];
  logic [31:0] dataQ[$];
  string       reqQ[$];

  logic [15:0] expSp;
  logic        expMask;
  logic [15:0] framePc;
  logic [7:0]  frameX, frameA, frameCcr;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (!ok) begin
      missCount++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  endtask

  task automatic pushExp(input int k, input logic [15:0] a, input logic [31:0] d, input string r);
    kindQ.push_back(k); addrQ.push_back(a); dataQ.push_back(d); reqQ.push_back(r);
  endtask

  task automatic compareItem(input int k, input logic [15:0] a, input logic [31:0] d);
    int ek; logic [15:0] ea; logic [31:0] ed; string er;
    if (kindQ.size() == 0) begin
      chk(1'b0, "R9", "unexpected bus event kind", 32'(k), 32'hFFFF_FFFF);
    end else begin
      ek = kindQ.pop_front(); ea = addrQ.pop_front(); ed = dataQ.pop_front(); er = reqQ.pop_front();
      chk(ek == k, er, "event kind", 32'(k), 32'(ek));
      chk(a == ea, er, "address/pc", {16'h0, a}, {16'h0, ea});
      chk(d == ed, er, "data", d, ed);
    end
  endtask

  // monitor: pops expected items as the design produces them
  always @(negedge clk) begin
    if (rstN && !sbOff) begin
      if (memWe)   compareItem(0, memAddr, {24'h0, memWdata});
      if (pcLoad)  compareItem(1, pcOut, 32'h0);
      if (regLoad) compareItem(2, pcOut, {8'h0, xOut, aOut, ccrOut});
    end
  end

  // driver-side expectation builders
  task automatic expectEntry(input logic [15:0] pc, input logic [7:0] x, input logic [7:0] a,
                             input logic [7:0] ccr, input logic [15:0] vec);
    logic [7:0] merged;
    merged = ccr; merged[3] = expMask;
    pushExp(0, expSp,          {24'h0, pc[7:0]},  "R5"); expSp = expSp - 16'd1;
    pushExp(0, expSp,          {24'h0, pc[15:8]}, "R5"); expSp = expSp - 16'd1;
    pushExp(0, expSp,          {24'h0, x},        "R5"); expSp = expSp - 16'd1;
    pushExp(0, expSp,          {24'h0, a},        "R5"); expSp = expSp - 16'd1;
    pushExp(0, expSp,          {24'h0, merged},   "R5"); expSp = expSp - 16'd1;
    pushExp(1, {bmem[vec[7:0]], bmem[vec[7:0] + 8'd1]}, 32'h0, "R6");
    framePc = pc; frameX = x; frameA = a; frameCcr = merged;
    expMask = 1'b1;
  endtask

  task automatic expectRti();
    pushExp(2, framePc, {8'h0, frameX, frameA, frameCcr}, "R8");
    expSp = expSp + 16'd5;
    expMask = frameCcr[3];
  endtask

  task automatic runBound(input bit s, input bit r, output bit fg);
    @(negedge clk);
    bound = 1'b1; opSwi = s; opRti = r;
    #1 fg = fetchGo;
    @(negedge clk);
    bound = 1'b0; opSwi = 1'b0; opRti = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic setRegs(input logic [15:0] pc, input logic [7:0] x, input logic [7:0] a,
                         input logic [7:0] ccr);
    pcIn = pc; xIn = x; aIn = a; ccrIn = ccr;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) timerReq = 1'b1;
    else if (which == 1) maskSet = 1'b1;
    else maskClr = 1'b1;
    @(negedge clk);
    timerReq = 1'b0; maskSet = 1'b0; maskClr = 1'b0;
  endtask

  task automatic checkState(input string req);
    chk(busy == 1'b0, req, "busy", 32'(busy), 32'h0);
    chk(maskOut == expMask, req, "mask", 32'(maskOut), 32'(expMask));
    chk(spOut == expSp, req, "sp", 32'(spOut), 32'(expSp));
    chk(kindQ.size() == 0, req, "scoreboard left", 32'(kindQ.size()), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R2", "watchdog expired", 32'h0, 32'h1);
    summary();
  end

  initial begin
    bit fg;
    for (int i = 0; i < 256; i++) bmem[i] = 8'h00;
    bmem[8'hF8] = 8'h12; bmem[8'hF9] = 8'h34;
    bmem[8'hFA] = 8'h56; bmem[8'hFB] = 8'h78;
    bmem[8'hFC] = 8'h9A; bmem[8'hFD] = 8'hBC;
    rstN = 1'b0; bound = 1'b0; opSwi = 1'b0; opRti = 1'b0;
    maskSet = 1'b0; maskClr = 1'b0; extIrqN = 1'b1; timerReq = 1'b0;
    setRegs(16'h0000, 8'h00, 8'h00, 8'h00);
    expSp = TOP; expMask = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(!pendExtOut && !pendTimOut, "R1", "pending after reset", {pendExtOut, pendTimOut}, 32'h0);
    chk(!memWe && !memRe, "R1", "bus idle after reset", {memWe, memRe}, 32'h0);
    checkState("R1");

    // R9: nothing pending -> normal fetch, no bus cycle
    runBound(1'b0, 1'b0, fg);
    chk(fg, "R9", "fetchGo", 32'(fg), 32'h1);
    checkState("R9");

    // R11, R2: timer pulse between boundaries is latched, no start
    pulse(0);
    repeat (3) @(negedge clk);
    chk(pendTimOut, "R11", "timer pending", 32'(pendTimOut), 32'h1);
    chk(!busy, "R2", "busy without boundary", 32'(busy), 32'h0);

    // R5, R6, R10: timer entry
    setRegs(16'h0410, 8'h11, 8'h22, 8'h05);
    expectEntry(16'h0410, 8'h11, 8'h22, 8'h05, 16'hFFF8);
    runBound(1'b0, 1'b0, fg);
    chk(!fg, "R6", "fetchGo on entry", 32'(fg), 32'h0);
    chk(!pendTimOut, "R10", "timer cleared", 32'(pendTimOut), 32'h0);
    checkState("R6");

    // R8: return restores and unmasks
    expectRti();
    runBound(1'b0, 1'b1, fg);
    checkState("R8");

    // R12, R3: masked requests latch and do not enter
    pulse(1);
    expMask = 1'b1;
    chk(maskOut, "R12", "mask set", 32'(maskOut), 32'h1);
    @(negedge clk); extIrqN = 1'b0;
    pulse(0);
    runBound(1'b0, 1'b0, fg);
    chk(fg, "R3", "masked boundary fetches", 32'(fg), 32'h1);
    chk(pendExtOut && pendTimOut, "R3", "both held", {pendExtOut, pendTimOut}, 32'h3);
    checkState("R3");

    // R7: software entry under mask, saved CCR bit 3 is 1
    setRegs(16'h0500, 8'h33, 8'h44, 8'hF0);
    expectEntry(16'h0500, 8'h33, 8'h44, 8'hF0, 16'hFFFC);
    runBound(1'b1, 1'b0, fg);
    chk(pendExtOut && pendTimOut, "R7", "hw still pending", {pendExtOut, pendTimOut}, 32'h3);
    checkState("R7");
    expectRti();
    runBound(1'b0, 1'b1, fg);
    checkState("R8");
    chk(maskOut, "R8", "mask restored 1", 32'(maskOut), 32'h1);

    // R4, R7: unmask; ext beats timer and beats the swi opcode
    pulse(2);
    expMask = 1'b0;
    chk(!maskOut, "R12", "mask clear", 32'(maskOut), 32'h0);
    setRegs(16'h0600, 8'h55, 8'h66, 8'h00);
    expectEntry(16'h0600, 8'h55, 8'h66, 8'h00, 16'hFFFA);
    runBound(1'b1, 1'b0, fg);
    chk(!pendExtOut, "R4", "ext cleared", 32'(pendExtOut), 32'h0);
    chk(pendTimOut, "R4", "timer left pending", 32'(pendTimOut), 32'h1);
    checkState("R4");

    // R10: pin held low gives no new request
    repeat (4) @(negedge clk);
    chk(!pendExtOut, "R10", "held-low pin", 32'(pendExtOut), 32'h0);
    expectRti();
    runBound(1'b0, 1'b1, fg);
    checkState("R8");

    // R3: timer served after mask clears
    setRegs(16'h0700, 8'h77, 8'h88, 8'h02);
    expectEntry(16'h0700, 8'h77, 8'h88, 8'h02, 16'hFFF8);
    runBound(1'b0, 1'b0, fg);
    chk(!pendTimOut, "R3", "timer served", 32'(pendTimOut), 32'h0);
    checkState("R3");
    expectRti();
    runBound(1'b0, 1'b1, fg);
    checkState("R8");

    // R10: fresh transition re-arms
    @(negedge clk); extIrqN = 1'b1;
    @(negedge clk); extIrqN = 1'b0;
    @(negedge clk);
    chk(pendExtOut, "R10", "re-armed", 32'(pendExtOut), 32'h1);

    // R1: reset in the middle of an entry
    sbOff = 1'b1;
    @(negedge clk); bound = 1'b1;
    @(negedge clk); bound = 1'b0;
    @(negedge clk);
    chk(busy, "R1", "entry under way", 32'(busy), 32'h1);
    rstN = 1'b0;
    @(negedge clk);
    chk(!busy && !memWe, "R1", "reset stops sequence", {busy, memWe}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    sbOff = 1'b0;
    expSp = TOP; expMask = 1'b0;
    chk(!pendExtOut && !pendTimOut, "R1", "pending cleared", {pendExtOut, pendTimOut}, 32'h0);
    checkState("R1");

    summary();
  end

endmodule